// File: doc/BRIEF.md
# Remote DMA Data Port

This block is the host-facing data window into the packet buffer of a network controller. Software loads a remote address and a remote byte count, then reads or writes packet memory by repeated accesses to a single data port. Each accepted access moves either one byte or one little-endian 16-bit word. The remote address then steps forward and the byte count steps down by the same amount. When the address runs into the end of the receive ring, it jumps back to the ring's first page. The access that empties the count raises a one-cycle completion pulse, which the interrupt logic elsewhere latches as its remote-transfer-done status.

The buffer is built from an even-byte bank and an odd-byte bank, so a word at any byte alignment moves in one cycle. A receive writer shares the buffer's write side at lower priority than the host. After reset a short sequencer fills the first 32 bytes of the buffer with the station address, each byte doubled, before host traffic is taken. Register decode and interrupt masking sit outside this block. The loads of address and count arrive here as plain strobes.

Top module: `rdma_data_port`

## Requirements
- R1: After reset, cur_addr and cur_count are 0, rdma_done is 0 and prom_loading is 1. prom_loading then stays high for exactly 16 clock cycles.
- R2: Once loading ends, buffer bytes 2i and 2i+1 both hold station byte i for i in 0..5 (byte i is station_mac[8i+7:8i]). For i in 6..15 they hold 0.
- R3: With word_mode low, a read returns the byte at cur_addr on host_rdata[7:0], with host_rdata[15:8] at 0. host_rdata_valid is high in the cycle after the read. A write stores host_wdata[7:0] at cur_addr.
- R4: With word_mode high, an access moves the low byte (bits 7:0) at cur_addr and the high byte (bits 15:8) at cur_addr+1. Any byte alignment is allowed.
- R5: Each accepted access advances cur_addr by 2 in word mode or by 1 in byte mode. cur_count falls by the same step. Without an access or a load, cur_addr holds.
- R6: If the advanced address equals ring_stop_page*256, cur_addr becomes ring_start_page*256 instead.
- R7: Buffer locations are selected by the address modulo MEM_BYTES (4096 by default). This applies to the high byte of a word too, so 0x1FFF selects 0xFFF and its word partner 0x000.
- R8: rdma_done pulses for one cycle, in the cycle after the access that takes cur_count from nonzero to zero.
- R9: A step larger than the remaining count leaves cur_count at 0, not wrapped. A word access with a count of 1 ends at 0 and raises rdma_done.
- R10: An access while cur_count is 0 still moves data and advances cur_addr. cur_count stays 0 and rdma_done stays low.
- R11: addr_load and count_load take effect at the next edge. They win over a host access made in the same cycle, and a count load in that cycle suppresses rdma_done.
- R12: A receive write is accepted (rx_wr_accept high) only when no host read or write is present and loading is over. An unaccepted receive write leaves the buffer unchanged.
- R13: While prom_loading is high, host reads and writes are ignored. cur_addr does not move and no host_rdata_valid appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1: 16-bit accesses, 0: byte accesses |
| ring_start_page | input | PAGE_W | First page of the receive ring |
| ring_stop_page | input | PAGE_W | Page one past the end of the ring |
| station_mac | input | 48 | Station address copied into the buffer after reset |
| addr_load | input | 1 | Load strobe for the remote address |
| addr_load_val | input | ADDR_W | Value for the remote address |
| count_load | input | 1 | Load strobe for the remote byte count |
| count_load_val | input | CNT_W | Value for the remote byte count |
| host_rd | input | 1 | Data-port read, one access per cycle high |
| host_wr | input | 1 | Data-port write, one access per cycle high |
| host_wdata | input | 16 | Write data |
| rx_wr_en | input | 1 | Receive writer byte request |
| rx_wr_addr | input | ADDR_W | Receive writer byte address |
| rx_wr_data | input | 8 | Receive writer byte |
| host_rdata | output | 16 | Read data |
| host_rdata_valid | output | 1 | host_rdata carries the result of last cycle's read |
| cur_addr | output | ADDR_W | Current remote address |
| cur_count | output | CNT_W | Current remote byte count |
| rdma_done | output | 1 | One-cycle pulse when the count empties |
| prom_loading | output | 1 | Station-address fill in progress |
| rx_wr_accept | output | 1 | Receive write taken this cycle |

## Verification
A wrong step, a missed ring wrap or a bad modulo reduction shows on cur_addr one cycle after the access. From then on every read returns data from the wrong place. A mis-steered bank select or a wrong byte order corrupts host_rdata in the cycle after the read. A count that wraps instead of clamping, or a completion raised at the wrong time, shows on cur_count and rdma_done at the same edge. Reading every stored pattern back through the data port exposes a lost or misplaced write on the first read of that location.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

   localparam int MAC_BYTES = 6;

   // returns station byte i, or zero in the padding region
   function automatic logic [7:0] mac_byte(input logic [47:0] mac, input int unsigned i);
      logic [7:0] b;
      b = 8'h00;
      for (int k = 0; k < MAC_BYTES; k++)
         if (i == k) b = mac[8*k +: 8];
      return b;
   endfunction

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_t;

endpackage

// File: rtl/rdma_byte_bank.sv
module rdma_byte_bank #(
   parameter int DEPTH = 2048,
   parameter int IDX_W = 11
) (
   input  logic             clk,
   input  logic [IDX_W-1:0] idx,
   input  logic             we,
   input  logic [7:0]       wd,
   input  logic             re,
   output logic [7:0]       q
);
   logic [7:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[idx] <= wd;
      if (re) q <= store[idx];
   end
endmodule

// File: rtl/rdma_prom_init.sv
module rdma_prom_init #(
   parameter int WORDS = 16,
   parameter int IDX_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [47:0]      mac,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic [7:0]       fill_byte
);
   localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;

   logic [CW-1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         busy   <= 1'b1;
      end else if (busy) begin
         if (step_q == CW'(WORDS - 1)) busy <= 1'b0;
         else step_q <= step_q + 1'b1;
      end
   end

   assign idx       = IDX_W'(step_q);
   assign fill_byte = rdma_pkg::mac_byte(mac, 32'(step_q));
endmodule

// File: rtl/rdma_addr_engine.sv
module rdma_addr_engine #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access_go,
   input  logic              step_two,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_load_val,
   input  logic              count_load,
   input  logic [CNT_W-1:0]  count_load_val,
   input  logic [PAGE_W-1:0] start_page,
   input  logic [PAGE_W-1:0] stop_page,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_count,
   output logic              done
);
   localparam int OFS_W = ADDR_W - PAGE_W;

   logic [CNT_W-1:0]  step;
   logic [ADDR_W-1:0] addr_inc, addr_nxt, stop_a, start_a;
   logic [CNT_W-1:0]  cnt_nxt;

   always_comb begin
      step     = step_two ? CNT_W'(2) : CNT_W'(1);
      stop_a   = {stop_page, {OFS_W{1'b0}}};
      start_a  = {start_page, {OFS_W{1'b0}}};
      addr_inc = cur_addr + ADDR_W'(step);
      addr_nxt = (addr_inc == stop_a) ? start_a : addr_inc;
      cnt_nxt  = (cur_count > step) ? (cur_count - step) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr  <= '0;
         cur_count <= '0;
         done      <= 1'b0;
      end else begin
         if (addr_load)      cur_addr <= addr_load_val;
         else if (access_go) cur_addr <= addr_nxt;

         if (count_load)     cur_count <= count_load_val;
         else if (access_go) cur_count <= cnt_nxt;

         done <= access_go && !count_load && (cur_count != '0) && (cnt_nxt == '0);
      end
   end
endmodule

// File: rtl/rdma_data_port.sv
module rdma_data_port #(
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter int PAGE_W     = 8,
   parameter int MEM_BYTES  = 4096,
   parameter int PROM_WORDS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_mode,
   input  logic [PAGE_W-1:0] ring_start_page,
   input  logic [PAGE_W-1:0] ring_stop_page,
   input  logic [47:0]       station_mac,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_load_val,
   input  logic              count_load,
   input  logic [CNT_W-1:0]  count_load_val,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [15:0]       host_wdata,
   input  logic              rx_wr_en,
   input  logic [ADDR_W-1:0] rx_wr_addr,
   input  logic [7:0]        rx_wr_data,
   output logic [15:0]       host_rdata,
   output logic              host_rdata_valid,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_count,
   output logic              rdma_done,
   output logic              prom_loading,
   output logic              rx_wr_accept
);
   localparam int BANK_DEPTH = MEM_BYTES / 2;
   localparam int MEM_AW     = $clog2(MEM_BYTES);
   localparam int IDX_W      = MEM_AW - 1;

   // elaboration-time parameter checks
   if ((MEM_BYTES & (MEM_BYTES - 1)) != 0 || MEM_BYTES < 64)
      $error("rdma_data_port: MEM_BYTES must be a power of two, at least 64");
   if (MEM_AW > ADDR_W)
      $error("rdma_data_port: MEM_BYTES exceeds the address range");
   if (PAGE_W >= ADDR_W)
      $error("rdma_data_port: PAGE_W must be narrower than ADDR_W");
   if (PROM_WORDS * 2 > MEM_BYTES)
      $error("rdma_data_port: PROM_WORDS does not fit the buffer");

   rdma_pkg::acc_kind_t kind;
   logic              host_go;
   logic [MEM_AW-1:0] a0, a1, ra;
   logic [IDX_W-1:0]  prom_idx;
   logic [7:0]        prom_byte;

   rdma_prom_init #(.WORDS(PROM_WORDS), .IDX_W(IDX_W)) u_prom (
      .clk       (clk),
      .rst_n     (rst_n),
      .mac       (station_mac),
      .busy      (prom_loading),
      .idx       (prom_idx),
      .fill_byte (prom_byte)
   );

   always_comb begin
      if (prom_loading)  kind = rdma_pkg::ACC_IDLE;
      else if (host_wr)  kind = rdma_pkg::ACC_WRITE;
      else if (host_rd)  kind = rdma_pkg::ACC_READ;
      else               kind = rdma_pkg::ACC_IDLE;
      host_go      = (kind != rdma_pkg::ACC_IDLE);
      rx_wr_accept = rx_wr_en && !host_rd && !host_wr && !prom_loading;
      a0           = cur_addr[MEM_AW-1:0];
      a1           = a0 + 1'b1;
      ra           = rx_wr_addr[MEM_AW-1:0];
   end

   rdma_addr_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_eng (
      .clk            (clk),
      .rst_n          (rst_n),
      .access_go      (host_go),
      .step_two       (word_mode),
      .addr_load      (addr_load),
      .addr_load_val  (addr_load_val),
      .count_load     (count_load),
      .count_load_val (count_load_val),
      .start_page     (ring_start_page),
      .stop_page      (ring_stop_page),
      .cur_addr       (cur_addr),
      .cur_count      (cur_count),
      .done           (rdma_done)
   );

   // bank 0 holds even byte addresses, bank 1 odd ones
   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic             host_lo;
      logic [IDX_W-1:0] idx;
      logic             we, re;
      logic [7:0]       wd, q;

      always_comb begin
         host_lo = (a0[0] == 1'(b));
         idx     = host_lo ? a0[MEM_AW-1:1] : a1[MEM_AW-1:1];
         we      = 1'b0;
         re      = 1'b0;
         wd      = host_wdata[7:0];
         if (prom_loading) begin
            we  = 1'b1;
            idx = prom_idx;
            wd  = prom_byte;
         end else if (kind == rdma_pkg::ACC_WRITE) begin
            we = host_lo | word_mode;
            wd = host_lo ? host_wdata[7:0] : host_wdata[15:8];
         end else if (kind == rdma_pkg::ACC_READ) begin
            re = 1'b1;
         end else if (rx_wr_accept) begin
            we  = (ra[0] == 1'(b));
            idx = ra[MEM_AW-1:1];
            wd  = rx_wr_data;
         end
      end

      rdma_byte_bank #(.DEPTH(BANK_DEPTH), .IDX_W(IDX_W)) u_bank (
         .clk (clk),
         .idx (idx),
         .we  (we),
         .wd  (wd),
         .re  (re),
         .q   (q)
      );
   end

   logic lo_odd_r, word_r, valid_r;
   logic [7:0] lo_b, hi_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_odd_r <= 1'b0;
         word_r   <= 1'b0;
         valid_r  <= 1'b0;
      end else begin
         valid_r <= (kind == rdma_pkg::ACC_READ);
         if (kind == rdma_pkg::ACC_READ) begin
            lo_odd_r <= a0[0];
            word_r   <= word_mode;
         end
      end
   end

   always_comb begin
      lo_b             = lo_odd_r ? g_bank[1].q : g_bank[0].q;
      hi_b             = lo_odd_r ? g_bank[0].q : g_bank[1].q;
      host_rdata       = word_r ? {hi_b, lo_b} : {8'h00, lo_b};
      host_rdata_valid = valid_r;
   end
endmodule

// File: rtl/rdma_data_port_chk.sv
module rdma_data_port_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_rd,
   input logic              host_wr,
   input logic              addr_load,
   input logic              count_load,
   input logic              host_rdata_valid,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [CNT_W-1:0]  cur_count,
   input logic              rdma_done,
   input logic              prom_loading,
   input logic              rx_wr_accept
);
   assert_done_on_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rdma_done |-> (cur_count == '0 && $past(cur_count) != '0));

   assert_valid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata_valid |-> $past(host_rd && !host_wr && !prom_loading));

   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rd && !host_wr && !addr_load) |=> $stable(cur_addr));

   assert_count_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !count_load |=> (cur_count <= $past(cur_count)));

   assert_quiet_while_loading_R13: assert property (@(posedge clk) disable iff (!rst_n)
      prom_loading |-> !host_rdata_valid);

   assert_host_over_rx_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd || host_wr) |-> !rx_wr_accept);
endmodule

bind rdma_data_port rdma_data_port_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .host_rd          (host_rd),
   .host_wr          (host_wr),
   .addr_load        (addr_load),
   .count_load       (count_load),
   .host_rdata_valid (host_rdata_valid),
   .cur_addr         (cur_addr),
   .cur_count        (cur_count),
   .rdma_done        (rdma_done),
   .prom_loading     (prom_loading),
   .rx_wr_accept     (rx_wr_accept)
);

// File: tb/rdma_data_port_tb_top.sv
module rdma_data_port_tb_top;
   localparam int MEM = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_mode = 1'b0;
   logic [7:0]  ring_start_page = 8'h04;
   logic [7:0]  ring_stop_page  = 8'h08;
   logic [47:0] station_mac = 48'hA5_4B_3C_2D_1E_0F;
   logic        addr_load = 1'b0, count_load = 1'b0;
   logic [15:0] addr_load_val = '0, count_load_val = '0;
   logic        host_rd = 1'b0, host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic        rx_wr_en = 1'b0;
   logic [15:0] rx_wr_addr = '0;
   logic [7:0]  rx_wr_data = '0;
   logic [15:0] host_rdata;
   logic        host_rdata_valid;
   logic [15:0] cur_addr, cur_count;
   logic        rdma_done, prom_loading, rx_wr_accept;

   always #5 clk = ~clk;

   rdma_data_port dut_i (.*);

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   logic [7:0]  mem_m [MEM];
   logic [15:0] m_addr = '0, m_cnt = '0;
   logic [15:0] exp_q [$];
   string       tag_q [$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && host_rdata_valid) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R3: unexpected read data actual 0x%0h expected none", host_rdata);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, 32'(host_rdata), 32'(e));
         end
      end
   end

   task automatic load(input logic [15:0] a, input logic [15:0] c);
      @(negedge clk);
      addr_load = 1; addr_load_val = a; count_load = 1; count_load_val = c;
      @(posedge clk); @(negedge clk);
      addr_load = 0; count_load = 0;
      m_addr = a; m_cnt = c;
   endtask

   task automatic model_step(output bit exp_done);
      logic [15:0] stp, inc;
      stp = word_mode ? 16'd2 : 16'd1;
      inc = m_addr + stp;
      if (inc == {ring_stop_page, 8'h00}) inc = {ring_start_page, 8'h00};
      exp_done = (m_cnt != 0) && (m_cnt <= stp);
      m_cnt = (m_cnt > stp) ? m_cnt - stp : 16'd0;
      m_addr = inc;
   endtask

   task automatic access(input bit is_wr, input logic [15:0] wd, input string tag);
      bit ed;
      logic [11:0] lo, hi;
      @(negedge clk);
      lo = m_addr[11:0];
      hi = lo + 12'd1;
      if (is_wr) begin
         mem_m[lo] = wd[7:0];
         if (word_mode) mem_m[hi] = wd[15:8];
      end else begin
         exp_q.push_back(word_mode ? {mem_m[hi], mem_m[lo]} : {8'h00, mem_m[lo]});
         tag_q.push_back(tag);
      end
      host_rd = !is_wr; host_wr = is_wr; host_wdata = wd;
      model_step(ed);
      @(posedge clk); @(negedge clk);
      host_rd = 0; host_wr = 0;
      chk({tag, " addr"}, 32'(cur_addr), 32'(m_addr));
      chk({tag, " count"}, 32'(cur_count), 32'(m_cnt));
      chk({tag, " done"}, 32'(rdma_done), 32'(ed));
   endtask

   task automatic rx_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      rx_wr_en = 1; rx_wr_addr = a; rx_wr_data = d;
      #1 chk("R12 accept idle", 32'(rx_wr_accept), 32'd1);
      mem_m[a[11:0]] = d;
      @(posedge clk); @(negedge clk);
      rx_wr_en = 0;
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      for (int i = 0; i < MEM; i++) mem_m[i] = 8'h00;
      for (int i = 0; i < 16; i++) begin
         mem_m[2*i]   = (i < 6) ? station_mac[8*i +: 8] : 8'h00;
         mem_m[2*i+1] = (i < 6) ? station_mac[8*i +: 8] : 8'h00;
      end

      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R1 addr", 32'(cur_addr), 0);
      chk("R1 count", 32'(cur_count), 0);
      chk("R1 done", 32'(rdma_done), 0);
      chk("R1 loading", 32'(prom_loading), 1);
      // R13: read during loading is ignored
      host_rd = 1;
      n = 0;
      while (prom_loading && n < 100) begin
         @(posedge clk); @(negedge clk);
         n++;
         if (n == 1) begin
            host_rd = 0;
            chk("R13 no valid", 32'(host_rdata_valid), 0);
            chk("R13 addr held", 32'(cur_addr), 0);
         end
      end
      chk("R1 loading length", n, 16);

      // R2, R3: station-address image, byte reads, R8 on the last one
      word_mode = 0;
      load(16'h0000, 16'd32);
      for (int i = 0; i < 32; i++) access(0, 16'h0, "R2 R3 prom read");

      // R4, R5: word writes then byte and odd-aligned word read-back
      word_mode = 1;
      load(16'h0100, 16'd8);
      access(1, 16'h1234, "R4 R5 word write");
      access(1, 16'hABCD, "R4 R5 word write");
      access(1, 16'h5A5A, "R4 R5 word write");
      access(1, 16'h0F0F, "R4 R5 word write");
      word_mode = 0;
      load(16'h0100, 16'd8);
      for (int i = 0; i < 8; i++) access(0, 16'h0, "R4 byte readback");
      word_mode = 1;
      load(16'h0101, 16'd2);
      access(0, 16'h0, "R4 odd word read");

      // R6: wrap at stop page
      word_mode = 0;
      load(16'h07FE, 16'd4);
      access(1, 16'h0011, "R6 write");
      access(1, 16'h0022, "R6 write wrap");
      access(1, 16'h0033, "R6 write");
      access(1, 16'h0044, "R6 write");
      load(16'h0400, 16'd2);
      access(0, 16'h0, "R6 readback");
      access(0, 16'h0, "R6 readback");

      // R9: word access with one byte left
      word_mode = 1;
      load(16'h0200, 16'd1);
      access(1, 16'h7788, "R9 saturate");

      // R10: count already zero
      load(16'h0200, 16'd0);
      access(0, 16'h0, "R10 zero-count read");

      // R7: modulo buffer size
      load(16'h1FFF, 16'd2);
      access(1, 16'hBEEF, "R7 wrap write");
      word_mode = 0;
      load(16'h0FFF, 16'd2);
      access(0, 16'h0, "R7 readback");
      access(0, 16'h0, "R7 readback");

      // R11: load wins over concurrent access
      load(16'h0100, 16'd4);
      @(negedge clk);
      exp_q.push_back({8'h00, mem_m[m_addr[11:0]]});
      tag_q.push_back("R11 concurrent read");
      host_rd = 1; addr_load = 1; addr_load_val = 16'h0300; count_load = 1; count_load_val = 16'd5;
      @(posedge clk); @(negedge clk);
      host_rd = 0; addr_load = 0; count_load = 0;
      m_addr = 16'h0300; m_cnt = 16'd5;
      chk("R11 addr", 32'(cur_addr), 32'h300);
      chk("R11 count", 32'(cur_count), 5);
      chk("R11 done", 32'(rdma_done), 0);

      // R12: receive writer, blocked by host
      rx_write(16'h0500, 8'h9C);
      rx_write(16'h0501, 8'h55);
      load(16'h0600, 16'd4);
      @(negedge clk);
      host_wr = 1; host_wdata = 16'h00E1;
      rx_wr_en = 1; rx_wr_addr = 16'h0501; rx_wr_data = 8'h77;
      #1 chk("R12 accept blocked", 32'(rx_wr_accept), 0);
      mem_m[12'h600] = 8'hE1;
      begin bit ed; model_step(ed); end
      @(posedge clk); @(negedge clk);
      host_wr = 0; rx_wr_en = 0;
      load(16'h0500, 16'd2);
      access(0, 16'h0, "R12 rx readback");
      access(0, 16'h0, "R12 blocked byte unchanged");
      load(16'h0600, 16'd1);
      access(0, 16'h0, "R12 host write landed");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R3: reads without data actual %0d expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule